// File: doc/BRIEF.md
# Remote Memory Command Header Decoder

This block sits behind a link receiver. It takes a received remote-memory-access command packet one symbol at a time. Each symbol is 9 bits wide: bit 8 set marks an end-of-packet (EOP) marker whose low byte carries no meaning, and bit 8 clear carries one data byte in bits 7:0. The block walks the header field by field. It captures a return path of variable length and keeps a running 8-bit header CRC. When the header is complete and its CRC byte matches, the block stops taking input and presents every decoded parameter on an authorisation interface.

An external agent answers the request with an acknowledge and an error flag. When the command is granted, the block pulses a go strobe for an execution stage. It then forwards the rest of the packet (data bytes, data CRC and EOP) unchanged on a payload port. When the command is refused, the block quietly discards the rest of the packet. The block also discards a packet and pulses an error output when the header is malformed: wrong packet type, CRC mismatch, or an EOP that arrives too early.

Top module: `rmh_cmd_decoder`

## Requirements
- R1: After reset, `in_ready` is 1 and `auth_req`, `cmd_go`, `hdr_err` and `pay_valid` are 0.
- R2: Header bytes are taken in this order: target address, command, key, return-path bytes (if any), initiator address, transaction ID (2 bytes), extended address, address (4 bytes), length (3 bytes), CRC. Multi-byte fields are assembled most-significant byte first and shown on the `auth_*` outputs.
- R3: The command-byte flags are: `flag_write` = bit 5, `flag_verify` = bit 4, `flag_reply` = bit 3, `flag_incr` = bit 2. `flag_rmw` is 1 exactly when bits 5:2 equal 0111.
- R4: Command bits 1:0 give a path length L. There are 4·L return-path bytes after the key. `rp_count` equals 4·L, and the i-th path byte appears on `rp_bytes[8i+7:8i]`.
- R5: The header CRC uses polynomial 0x07 with initial value 0x00. Each byte is fed in least-significant bit first, with feedback = crc[7] XOR bit, followed by crc = (crc<<1) XOR (feedback ? 0x07 : 0). The CRC runs over every header byte from the target address up to the last length byte. When the next byte equals the CRC, `auth_req` is 1 from the cycle after that byte is accepted.
- R6: On a CRC mismatch, `hdr_err` is 1 for exactly one cycle and no request is raised. The remaining symbols up to and including EOP are dropped, and the next packet decodes normally.
- R7: An EOP before the CRC byte (but after the target address) pulses `hdr_err` for one cycle and returns the block to idle. An EOP at idle is ignored.
- R8: A command byte whose bits 7:6 are not 01 pulses `hdr_err` for one cycle, and the packet is dropped up to EOP.
- R9: While `auth_req` is 1, `in_ready` is 0 and all `auth_*` outputs hold steady.
- R10: A grant (`auth_ack`=1 with `auth_err`=0) gives `cmd_go`=1 for one cycle in the next cycle and clears `auth_req`. Every following symbol up to and including EOP then appears on `pay_valid`/`pay_sym`.
- R11: A refusal (`auth_ack`=1 with `auth_err`=1) gives no `cmd_go`. The rest of the packet produces no `pay_valid`, and the block then accepts a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input symbol valid |
| in_sym | input | 9 | Bit 8 EOP marker, bits 7:0 data |
| in_ready | output | 1 | Block accepts a symbol this cycle |
| auth_req | output | 1 | Authorisation request |
| auth_tla | output | 8 | Target logical address |
| auth_cmd | output | 8 | Command byte |
| auth_key | output | 8 | Key |
| auth_ila | output | 8 | Initiator logical address |
| auth_tid | output | 16 | Transaction ID |
| auth_ext | output | 8 | Extended address |
| auth_addr | output | 32 | Address |
| auth_len | output | 24 | Data length |
| flag_write | output | 1 | Write command |
| flag_verify | output | 1 | Verify before write |
| flag_reply | output | 1 | Reply requested |
| flag_incr | output | 1 | Incrementing address |
| flag_rmw | output | 1 | Read-modify-write |
| rp_count | output | 4 | Number of return-path bytes |
| rp_bytes | output | 96 | Return-path bytes, byte i at bits 8i+7:8i |
| auth_ack | input | 1 | Authorisation answer strobe |
| auth_err | input | 1 | Answer is a refusal |
| cmd_go | output | 1 | One-cycle release to the execution stage |
| pay_valid | output | 1 | Forwarded payload symbol valid |
| pay_sym | output | 9 | Forwarded payload symbol |
| hdr_err | output | 1 | One-cycle header error pulse |

## Verification
Every result is due a fixed number of cycles after the symbol that causes it:
- `auth_req`, `hdr_err` and the captured fields change at the clock edge that accepts the CRC byte, the offending command byte, or the early EOP.
- `cmd_go` rises at the edge that samples the grant.
- `pay_valid` follows the input in the same cycle once the block is forwarding.

The bench drives inputs on the falling edge and samples on the next falling edge. Every check therefore lands exactly one edge after its cause. Forwarded symbols, go strobes and error pulses are also counted on rising edges, so a pulse that is missing or repeated between checks still shows up.

// File: rtl/rmh_pkg.sv
package rmh_pkg;
  typedef enum logic [3:0] {
    ST_TLA, ST_CMD, ST_KEY, ST_PATH, ST_ILA, ST_TID, ST_EXT,
    ST_ADDR, ST_LEN, ST_CRC, ST_AUTH, ST_PASS, ST_DROP
  } rmh_state_e;

  localparam int BIT_WRITE  = 5;
  localparam int BIT_VERIFY = 4;
  localparam int BIT_REPLY  = 3;
  localparam int BIT_INCR   = 2;
  localparam int TID_BYTES  = 2;
  localparam int ADDR_BYTES = 4;
  localparam int LEN_BYTES  = 3;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      fb = c[7] ^ b[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/rmh_crc8.sv
module rmh_crc8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import rmh_pkg::*;
  logic [7:0] crc_d;

  always_comb begin
    crc_d = crc8_step(clr ? 8'h00 : crc, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc <= 8'h00;
    else if (en) crc <= crc_d;
  end
endmodule

// File: rtl/rmh_path_store.sv
module rmh_path_store #(
  parameter int SLOTS = 12,
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  output logic [SLOTS*8-1:0] bytes_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bytes_o[g*8 +: 8] <= 8'h00;
      else if (hit) bytes_o[g*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/rmh_cmd_decoder.sv
module rmh_cmd_decoder #(
  parameter int PATH_UNIT = 4,
  parameter int PL_W      = 2,
  localparam int PATH_SLOTS = PATH_UNIT * ((1 << PL_W) - 1),
  localparam int CNT_W      = $clog2(PATH_SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [8:0]              in_sym,
  output logic                    in_ready,
  output logic                    auth_req,
  output logic [7:0]              auth_tla,
  output logic [7:0]              auth_cmd,
  output logic [7:0]              auth_key,
  output logic [7:0]              auth_ila,
  output logic [15:0]             auth_tid,
  output logic [7:0]              auth_ext,
  output logic [31:0]             auth_addr,
  output logic [23:0]             auth_len,
  output logic                    flag_write,
  output logic                    flag_verify,
  output logic                    flag_reply,
  output logic                    flag_incr,
  output logic                    flag_rmw,
  output logic [CNT_W-1:0]        rp_count,
  output logic [PATH_SLOTS*8-1:0] rp_bytes,
  input  logic                    auth_ack,
  input  logic                    auth_err,
  output logic                    cmd_go,
  output logic                    pay_valid,
  output logic [8:0]              pay_sym,
  output logic                    hdr_err
);
  import rmh_pkg::*;

  rmh_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic go_d, err_d;
  logic acc, is_eop, in_hdr;
  logic [7:0] byt, crc_q;
  logic ld_tla, ld_cmd, ld_key, ld_ila, ld_tid, ld_ext, ld_addr, ld_len, path_we;

  assign byt      = in_sym[7:0];
  assign is_eop   = in_sym[8];
  assign in_ready = (state_q != ST_AUTH);
  assign acc      = in_valid && in_ready;
  assign in_hdr   = (state_q >= ST_CMD) && (state_q <= ST_CRC);
  assign rp_count = CNT_W'(auth_cmd[PL_W-1:0]) * CNT_W'(PATH_UNIT);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    go_d    = 1'b0;
    err_d   = 1'b0;
    {ld_tla, ld_cmd, ld_key, ld_ila, ld_tid, ld_ext, ld_addr, ld_len, path_we} = '0;
    if (acc && is_eop && in_hdr) begin
      err_d   = 1'b1;
      state_d = ST_TLA;
    end else begin
      case (state_q)
        ST_TLA:  if (acc && !is_eop) begin ld_tla = 1'b1; state_d = ST_CMD; end
        ST_CMD:  if (acc) begin
                   if (byt[7:6] != 2'b01) begin err_d = 1'b1; state_d = ST_DROP; end
                   else begin ld_cmd = 1'b1; state_d = ST_KEY; end
                 end
        ST_KEY:  if (acc) begin
                   ld_key  = 1'b1;
                   cnt_d   = '0;
                   state_d = (auth_cmd[PL_W-1:0] != '0) ? ST_PATH : ST_ILA;
                 end
        ST_PATH: if (acc) begin
                   path_we = 1'b1;
                   cnt_d   = cnt_q + 1'b1;
                   if (cnt_q == rp_count - CNT_W'(1)) begin cnt_d = '0; state_d = ST_ILA; end
                 end
        ST_ILA:  if (acc) begin ld_ila = 1'b1; cnt_d = '0; state_d = ST_TID; end
        ST_TID:  if (acc) begin
                   ld_tid = 1'b1;
                   cnt_d  = cnt_q + 1'b1;
                   if (cnt_q == CNT_W'(TID_BYTES - 1)) begin cnt_d = '0; state_d = ST_EXT; end
                 end
        ST_EXT:  if (acc) begin ld_ext = 1'b1; cnt_d = '0; state_d = ST_ADDR; end
        ST_ADDR: if (acc) begin
                   ld_addr = 1'b1;
                   cnt_d   = cnt_q + 1'b1;
                   if (cnt_q == CNT_W'(ADDR_BYTES - 1)) begin cnt_d = '0; state_d = ST_LEN; end
                 end
        ST_LEN:  if (acc) begin
                   ld_len = 1'b1;
                   cnt_d  = cnt_q + 1'b1;
                   if (cnt_q == CNT_W'(LEN_BYTES - 1)) begin cnt_d = '0; state_d = ST_CRC; end
                 end
        ST_CRC:  if (acc) begin
                   if (byt == crc_q) state_d = ST_AUTH;
                   else begin err_d = 1'b1; state_d = ST_DROP; end
                 end
        ST_AUTH: if (auth_ack) begin
                   if (auth_err) state_d = ST_DROP;
                   else begin go_d = 1'b1; state_d = ST_PASS; end
                 end
        ST_PASS, ST_DROP: if (acc && is_eop) state_d = ST_TLA;
        default: state_d = ST_TLA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TLA;
      cnt_q   <= '0;
      cmd_go  <= 1'b0;
      hdr_err <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cmd_go  <= go_d;
      hdr_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auth_tla <= '0; auth_cmd <= '0; auth_key <= '0; auth_ila <= '0;
      auth_tid <= '0; auth_ext <= '0; auth_addr <= '0; auth_len <= '0;
    end else begin
      if (ld_tla)  auth_tla  <= byt;
      if (ld_cmd)  auth_cmd  <= byt;
      if (ld_key)  auth_key  <= byt;
      if (ld_ila)  auth_ila  <= byt;
      if (ld_tid)  auth_tid  <= {auth_tid[7:0], byt};
      if (ld_ext)  auth_ext  <= byt;
      if (ld_addr) auth_addr <= {auth_addr[23:0], byt};
      if (ld_len)  auth_len  <= {auth_len[15:0], byt};
    end
  end

  rmh_crc8 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (acc && !is_eop && ((state_q == ST_TLA) || (in_hdr && state_q != ST_CRC))),
    .clr   (state_q == ST_TLA),
    .din   (byt),
    .crc   (crc_q)
  );

  rmh_path_store #(.SLOTS(PATH_SLOTS), .IDX_W(CNT_W)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (path_we),
    .wr_idx  (cnt_q),
    .wr_data (byt),
    .bytes_o (rp_bytes)
  );

  assign auth_req    = (state_q == ST_AUTH);
  assign pay_valid   = (state_q == ST_PASS) && in_valid;
  assign pay_sym     = in_sym;
  assign flag_write  = auth_cmd[BIT_WRITE];
  assign flag_verify = auth_cmd[BIT_VERIFY];
  assign flag_reply  = auth_cmd[BIT_REPLY];
  assign flag_incr   = auth_cmd[BIT_INCR];
  assign flag_rmw    = (auth_cmd[5:2] == 4'b0111);
endmodule

// File: rtl/rmh_cmd_decoder_chk.sv
module rmh_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        auth_req,
  input logic        auth_ack,
  input logic        auth_err,
  input logic [15:0] auth_tid,
  input logic [31:0] auth_addr,
  input logic        cmd_go,
  input logic        pay_valid,
  input logic        hdr_err
);
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    auth_req |-> !in_ready);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_req && !auth_ack) |=> (auth_req && $stable(auth_addr) && $stable(auth_tid)));
  a_r10_go_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> $past(auth_req && auth_ack && !auth_err));
  a_r10_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go);
  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> !hdr_err);
  a_r6_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> !auth_req);
  a_r11_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_req && auth_ack && auth_err) |=> (!cmd_go && !pay_valid && !auth_req));
endmodule

bind rmh_cmd_decoder rmh_cmd_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .auth_req  (auth_req),
  .auth_ack  (auth_ack),
  .auth_err  (auth_err),
  .auth_tid  (auth_tid),
  .auth_addr (auth_addr),
  .cmd_go    (cmd_go),
  .pay_valid (pay_valid),
  .hdr_err   (hdr_err)
);

// File: tb/rmh_cmd_decoder_tb.sv
`timescale 1ns/1ps
module rmh_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [8:0]  in_sym = '0;
  logic        auth_ack = 1'b0;
  logic        auth_err = 1'b0;
  logic        in_ready, auth_req, cmd_go, pay_valid, hdr_err;
  logic [7:0]  auth_tla, auth_cmd, auth_key, auth_ila, auth_ext;
  logic [15:0] auth_tid;
  logic [31:0] auth_addr;
  logic [23:0] auth_len;
  logic        flag_write, flag_verify, flag_reply, flag_incr, flag_rmw;
  logic [3:0]  rp_count;
  logic [95:0] rp_bytes;
  logic [8:0]  pay_sym;

  int checks = 0, errors = 0;
  int pay_cnt = 0, go_cnt = 0, err_cnt = 0;
  logic [7:0] bcrc;

  always #10 clk = ~clk;

  rmh_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym), .in_ready(in_ready),
    .auth_req(auth_req), .auth_tla(auth_tla), .auth_cmd(auth_cmd), .auth_key(auth_key),
    .auth_ila(auth_ila), .auth_tid(auth_tid), .auth_ext(auth_ext), .auth_addr(auth_addr),
    .auth_len(auth_len), .flag_write(flag_write), .flag_verify(flag_verify),
    .flag_reply(flag_reply), .flag_incr(flag_incr), .flag_rmw(flag_rmw),
    .rp_count(rp_count), .rp_bytes(rp_bytes), .auth_ack(auth_ack), .auth_err(auth_err),
    .cmd_go(cmd_go), .pay_valid(pay_valid), .pay_sym(pay_sym), .hdr_err(hdr_err)
  );

  always @(posedge clk) begin
    if (pay_valid) pay_cnt++;
    if (cmd_go)    go_cnt++;
    if (hdr_err)   err_cnt++;
  end

  function automatic logic [7:0] crc_f(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] s);
    @(negedge clk);
    in_valid = 1'b1;
    in_sym   = s;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_b(input logic [7:0] b);
    bcrc = crc_f(bcrc, b);
    send({1'b0, b});
  endtask

  task automatic send_header(input logic [7:0] tla, cmd, key, input logic [95:0] rp,
                             input logic [7:0] ila, input logic [15:0] tid,
                             input logic [7:0] ext, input logic [31:0] addr,
                             input logic [23:0] len, input logic [7:0] flip);
    bcrc = 8'h00;
    send_b(tla); send_b(cmd); send_b(key);
    for (int i = 0; i < 4 * int'(cmd[1:0]); i++) send_b(rp[8*i +: 8]);
    send_b(ila); send_b(tid[15:8]); send_b(tid[7:0]); send_b(ext);
    for (int i = 3; i >= 0; i--) send_b(addr[8*i +: 8]);
    for (int i = 2; i >= 0; i--) send_b(len[8*i +: 8]);
    send({1'b0, bcrc ^ flip});
    idle();
  endtask

  task automatic answer(input logic rej);
    auth_ack = 1'b1;
    auth_err = rej;
    @(posedge clk);
    @(negedge clk);
    auth_ack = 1'b0;
    auth_err = 1'b0;
  endtask

  task automatic tail(input int n);
    for (int i = 0; i < n; i++) send({1'b0, 8'(i + 8'h30)});
    send(9'h100);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 in_ready", 96'(in_ready), 96'd1);
    chk("R1 auth_req", 96'(auth_req), 96'd0);
    chk("R1 cmd_go", 96'(cmd_go), 96'd0);
    chk("R1 hdr_err", 96'(hdr_err), 96'd0);
    chk("R1 pay_valid", 96'(pay_valid), 96'd0);
  endtask

  task automatic t_write();
    int g0, p0;
    send_header(8'hfa, 8'h6c, 8'h20, '0, 8'hfe, 16'habcd, 8'h00, 32'h001f4502, 24'd8, 8'h00);
    chk("R5 auth_req after crc", 96'(auth_req), 96'd1);
    chk("R2 tla", 96'(auth_tla), 96'hfa);
    chk("R2 key", 96'(auth_key), 96'h20);
    chk("R2 ila", 96'(auth_ila), 96'hfe);
    chk("R2 tid", 96'(auth_tid), 96'habcd);
    chk("R2 addr", 96'(auth_addr), 96'h001f4502);
    chk("R2 len", 96'(auth_len), 96'd8);
    chk("R3 flags 6c", 96'({flag_write, flag_verify, flag_reply, flag_incr, flag_rmw}), 96'b10110);
    chk("R4 no path", 96'(rp_count), 96'd0);
    repeat (3) @(negedge clk);
    chk("R9 stalled", 96'({in_ready, auth_req}), 96'b01);
    chk("R9 addr held", 96'(auth_addr), 96'h001f4502);
    g0 = go_cnt;
    answer(1'b0);
    chk("R10 go pulse", 96'({cmd_go, auth_req}), 96'b10);
    p0 = pay_cnt;
    tail(9);
    chk("R10 go single", 96'(go_cnt - g0), 96'd1);
    chk("R10 payload forwarded", 96'(pay_cnt - p0), 96'd10);
    chk("R10 back to idle", 96'(in_ready), 96'd1);
  endtask

  task automatic t_verify();
    send_header(8'hb5, 8'h7c, 8'ha5, '0, 8'h5a, 16'h1122, 8'h00, 32'ha5a5a5a5, 24'd8, 8'h00);
    chk("R3 flags 7c", 96'({flag_write, flag_verify, flag_reply, flag_incr, flag_rmw}), 96'b11110);
    chk("R2 cmd", 96'(auth_cmd), 96'h7c);
    answer(1'b0);
    tail(9);
  endtask

  task automatic t_read_path();
    send_header(8'h23, 8'h4d, 8'h1f, 96'h02010000, 8'h22, 16'h0001, 8'h00,
                32'h51a40dc7, 24'd16, 8'h00);
    chk("R5 auth_req read", 96'(auth_req), 96'd1);
    chk("R4 rp_count 4", 96'(rp_count), 96'd4);
    chk("R4 rp bytes", 96'(rp_bytes[31:0]), 96'h02010000);
    chk("R2 ila after path", 96'(auth_ila), 96'h22);
    chk("R2 addr after path", 96'(auth_addr), 96'h51a40dc7);
    chk("R3 flags 4d", 96'({flag_write, flag_verify, flag_reply, flag_incr, flag_rmw}), 96'b00110);
    answer(1'b0);
    tail(0);
    send_header(8'h11, 8'h4f, 8'h01, 96'h0b0a09080706050403020100, 8'h33, 16'h7788,
                8'h05, 32'hdeadbeef, 24'h012345, 8'h00);
    chk("R4 rp_count 12", 96'(rp_count), 96'd12);
    chk("R4 rp bytes 12", rp_bytes, 96'h0b0a09080706050403020100);
    chk("R2 ext", 96'(auth_ext), 96'h05);
    chk("R2 len msb first", 96'(auth_len), 96'h012345);
    answer(1'b0);
    tail(0);
  endtask

  task automatic t_rmw_reject();
    int g0, p0;
    send_header(8'h43, 8'h5c, 8'hfc, '0, 8'he5, 16'h0112, 8'h00, 32'h12345678, 24'd8, 8'h00);
    chk("R3 rmw flag", 96'(flag_rmw), 96'd1);
    g0 = go_cnt; p0 = pay_cnt;
    answer(1'b1);
    chk("R11 no req", 96'(auth_req), 96'd0);
    tail(9);
    chk("R11 no go", 96'(go_cnt - g0), 96'd0);
    chk("R11 no payload", 96'(pay_cnt - p0), 96'd0);
    chk("R11 ready again", 96'(in_ready), 96'd1);
  endtask

  task automatic t_bad_crc();
    int e0, p0;
    e0 = err_cnt; p0 = pay_cnt;
    send_header(8'h01, 8'h6c, 8'h02, '0, 8'h03, 16'h0405, 8'h06, 32'h0708090a, 24'd4, 8'h01);
    chk("R6 err pulse", 96'({hdr_err, auth_req}), 96'b10);
    tail(5);
    chk("R6 err single", 96'(err_cnt - e0), 96'd1);
    chk("R6 dropped", 96'(pay_cnt - p0), 96'd0);
    send_header(8'h23, 8'h4c, 8'h1f, '0, 8'h22, 16'h0002, 8'h00, 32'h0, 24'd4, 8'h00);
    chk("R6 recovery", 96'(auth_req), 96'd1);
    answer(1'b0);
    tail(0);
  endtask

  task automatic t_early_eop();
    int e0;
    e0 = err_cnt;
    send(9'h100);
    idle();
    chk("R7 idle eop ignored", 96'(hdr_err), 96'd0);
    send(9'h0fa); send(9'h06c); send(9'h020); send(9'h100);
    idle();
    chk("R7 early eop err", 96'(hdr_err), 96'd1);
    @(negedge clk);
    chk("R7 err count", 96'(err_cnt - e0), 96'd1);
    send_header(8'h23, 8'h4c, 8'h1f, '0, 8'h22, 16'h0003, 8'h00, 32'h10, 24'd4, 8'h00);
    chk("R7 next packet ok", 96'(auth_req), 96'd1);
    answer(1'b0);
    tail(0);
  endtask

  task automatic t_bad_type();
    send(9'h0fa); send(9'h08c);
    idle();
    chk("R8 type err", 96'(hdr_err), 96'd1);
    tail(12);
    chk("R8 no request", 96'(auth_req), 96'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_verify();
    t_read_path();
    t_rmw_reject();
    t_bad_crc();
    t_early_eop();
    t_bad_type();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule